// File: doc/BRIEF.md
# Burst Backing-Store Timing Model

This block stands behind a cache as its next memory level and answers block fetches with the timing of a burst-capable DRAM. A request presents a start word address and a length in words. The block then returns words one per beat. The column part of the address advances by one for each beat, and the row part stays fixed. The beat schedule is set by four parameters: one cycle to carry the address, a long access before the first word, a shorter spacing between later words, and one cycle to hand each word back.

With the default timing, a one-word fetch completes 52 cycles after it is accepted and a four-word fetch completes after 82 cycles. For every fetch the block measures the cycles from acceptance to the final word. It presents that figure alongside the final word so that a performance check can read it directly. Contents live in an internal word array, which a simple write port fills. Only one fetch is in flight at a time.

Top module: `burst_store_model`

## Requirements
- R1: While reset is low and after its release, `rd_valid_o`, `rd_last_o` and `busy_o` are 0 and `penalty_o` is 0 until the first fetch completes.
- R2: A fetch is accepted on a clock edge where `req_i` is 1 and `busy_o` is 0; `busy_o` is 1 from the cycle after that edge.
- R3: The first word's `rd_valid_o` pulse comes in the cycle after edge A+52, where A is the acceptance edge (1 address + 50 access + 1 return cycle).
- R4: Each later word's pulse comes exactly 10 cycles after the previous one, and `rd_valid_o` is a single-cycle pulse per word.
- R5: Word k of a fetch is read from row `addr[7:4]` and column `(addr[3:0] + k) mod 16`: the column wraps inside its 16-word row, and the row never changes.
- R6: `req_len_i` is the word count of the fetch, and a value of 0 fetches one word. `rd_last_o` is 1 only together with the final word's `rd_valid_o`.
- R7: In the final word's cycle, `penalty_o` equals the cycle count from the acceptance edge to the final word's edge: 52 + 10*(words-1), that is 52 for one word and 82 for four. It holds that value until the next fetch completes.
- R8: A request made while `busy_o` is 1 is dropped and produces no words. `busy_o` is 0 in the final word's cycle, so a request in that cycle is accepted on the next edge.
- R9: When `wr_en_i` is 1, `wr_data_i` is stored at `wr_addr_i` on that edge, and a later fetch returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Fetch request |
| req_addr_i | input | 8 | Start word address (row in upper 4 bits, column in lower 4) |
| req_len_i | input | 4 | Words to fetch, 0 meaning 1 |
| wr_en_i | input | 1 | Store a word |
| wr_addr_i | input | 8 | Store address |
| wr_data_i | input | 32 | Store data |
| busy_o | output | 1 | Fetch in progress |
| rd_valid_o | output | 1 | Returned word present |
| rd_data_o | output | 32 | Returned word |
| rd_last_o | output | 1 | Final word of the fetch |
| penalty_o | output | 16 | Cycles of the last completed fetch |

## Verification
A returned word is due in the cycle after edge A+52+10k, where A is the acceptance edge and k is the beat number. The bench counts clock edges from reset. On each accepted request it enqueues the due edge, data and last flag of every beat. It then compares valid, data, last, busy and the penalty figure at every falling edge against that queue. A request is taken to be accepted only if the bench's own busy window, which runs from A to the final beat's edge, has closed. Because of this, dropped requests and back-to-back requests in the final-word cycle are checked on the same per-cycle schedule.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    SCH_IDLE = 1'b0,
    SCH_RUN  = 1'b1
  } sched_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/burst_word_array.sv
module burst_word_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      cells_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) begin
      rd_q <= cells_q[rd_addr_i];
    end
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] rd_addr_o
);

  localparam int unsigned ROW_W = ADDR_W - COL_W;

  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             en;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    en    = start_i | step_i;
    if (start_i) begin
      row_d = addr_i[ADDR_W-1:COL_W];
      col_d = addr_i[COL_W-1:0];
    end else if (step_i) begin
      col_d = col_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (en) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign rd_addr_o = {row_q, col_q};

  assert_row_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> $stable(row_q));

  assert_col_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> col_q == $past(col_q) + COL_W'(1));

endmodule

// File: rtl/burst_sched.sv
module burst_sched
  import burst_pkg::*;
#(
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned PEN_W     = 16,
  parameter int unsigned ADDR_CYC  = 1,
  parameter int unsigned FIRST_CYC = 50,
  parameter int unsigned NEXT_CYC  = 10,
  parameter int unsigned RET_CYC   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             start_o,
  output logic             step_o,
  output logic             last_step_o,
  output logic [PEN_W-1:0] pen_o
);

  localparam int unsigned LAT0   = ADDR_CYC + FIRST_CYC + RET_CYC;
  localparam int unsigned WAIT_W = $clog2(max_of(LAT0, NEXT_CYC)) + 1;

  sched_state_e     st_q, st_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [LEN_W-1:0]  nwords_q, nwords_d;
  logic [PEN_W-1:0]  cyc_q, cyc_d;
  logic [PEN_W-1:0]  pen_q, pen_d;
  logic              accept, step, last_step, run;

  always_comb begin
    run       = (st_q == SCH_RUN);
    accept    = req_i && !run;
    step      = run && (wait_q == '0);
    last_step = step && (left_q == LEN_W'(1));
    st_d      = st_q;
    wait_d    = wait_q;
    left_d    = left_q;
    nwords_d  = nwords_q;
    cyc_d     = cyc_q;
    pen_d     = pen_q;
    if (accept) begin
      st_d     = SCH_RUN;
      wait_d   = WAIT_W'(LAT0 - 1);
      left_d   = (len_i == '0) ? LEN_W'(1) : len_i;
      nwords_d = (len_i == '0) ? LEN_W'(1) : len_i;
      cyc_d    = PEN_W'(1);
    end else if (run) begin
      cyc_d = cyc_q + PEN_W'(1);
      if (step) begin
        left_d = left_q - LEN_W'(1);
        wait_d = WAIT_W'(NEXT_CYC - 1);
        if (last_step) begin
          st_d  = SCH_IDLE;
          pen_d = cyc_q;
        end
      end else begin
        wait_d = wait_q - WAIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SCH_IDLE;
      wait_q   <= '0;
      left_q   <= '0;
      nwords_q <= '0;
      cyc_q    <= '0;
      pen_q    <= '0;
    end else begin
      st_q     <= st_d;
      wait_q   <= wait_d;
      left_q   <= left_d;
      nwords_q <= nwords_d;
      cyc_q    <= cyc_d;
      pen_q    <= pen_d;
    end
  end

  assign busy_o      = run;
  assign start_o     = accept;
  assign step_o      = step;
  assign last_step_o = last_step;
  assign pen_o       = pen_q;

  assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= WAIT_W'(max_of(LAT0, NEXT_CYC) - 1));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last_step) |=> (run && $stable(nwords_q)));

  assert_pen_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> pen_q == PEN_W'(LAT0) + (PEN_W'(nwords_q) - PEN_W'(1)) * PEN_W'(NEXT_CYC));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> run);

endmodule

// File: rtl/burst_store_model.sv
module burst_store_model #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned COL_W     = 4,
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned PEN_W     = 16,
  parameter int unsigned ADDR_CYC  = 1,
  parameter int unsigned FIRST_CYC = 50,
  parameter int unsigned NEXT_CYC  = 10,
  parameter int unsigned RET_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic [PEN_W-1:0]  penalty_o
);

  logic              start, step, last_step;
  logic [ADDR_W-1:0] rd_addr;
  logic              valid_q, valid_d;
  logic              last_q, last_d;

  burst_sched #(
    .LEN_W    (LEN_W),
    .PEN_W    (PEN_W),
    .ADDR_CYC (ADDR_CYC),
    .FIRST_CYC(FIRST_CYC),
    .NEXT_CYC (NEXT_CYC),
    .RET_CYC  (RET_CYC)
  ) i_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .len_i      (req_len_i),
    .busy_o     (busy_o),
    .start_o    (start),
    .step_o     (step),
    .last_step_o(last_step),
    .pen_o      (penalty_o)
  );

  burst_addr_gen #(
    .ADDR_W(ADDR_W),
    .COL_W (COL_W)
  ) i_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .addr_i   (req_addr_i),
    .step_i   (step),
    .rd_addr_o(rd_addr)
  );

  burst_word_array #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) i_array (
    .clk      (clk),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_en_i  (step),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data_o)
  );

  always_comb begin
    valid_d = step;
    last_d  = last_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      last_q  <= last_d;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_last_o  = last_q;

  assert_last_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last_o |-> rd_valid_o);

  assert_idle_at_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last_o |-> !busy_o);

  generate
    if (NEXT_CYC > 1) begin : g_gap
      assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);
    end
  endgenerate

endmodule

// File: tb/test_burst_store_model.sv
module test_burst_store_model;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [7:0]  req_addr;
  logic [3:0]  req_len;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        busy;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rd_last;
  logic [15:0] penalty;

  burst_store_model i_burst_store_model (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .req_addr_i(req_addr),
    .req_len_i (req_len),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .busy_o    (busy),
    .rd_valid_o(rd_valid),
    .rd_data_o (rd_data),
    .rd_last_o (rd_last),
    .penalty_o (penalty)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cnt = 0;
  int acc_e = -1;
  int last_e = -1;
  bit live = 1'b0;
  bit done = 1'b0;
  logic [31:0] mdl [256];
  int          q_cyc [$];
  logic [31:0] q_dat [$];
  bit          q_last [$];
  int          q_pen [$];

  always @(posedge clk) if (rst_n) cnt <= cnt + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", tag, cnt, act, exp);
    end
  endtask

  // per-cycle comparison against the queued schedule (R2 R3 R4 R5 R6 R7 R8)
  always @(negedge clk) begin
    if (live) begin
      bit ev;
      bit eb;
      ev = (q_cyc.size() > 0) && (q_cyc[0] == cnt);
      eb = (acc_e <= cnt) && (cnt < last_e);
      check(busy == eb, "R2/R8 busy", busy, eb);
      check(rd_valid == ev, "R3/R4 valid", rd_valid, ev);
      if (ev) begin
        check(rd_data == q_dat[0], "R5/R9 data", rd_data, q_dat[0]);
        check(rd_last == q_last[0], "R6 last", rd_last, q_last[0]);
        if (q_last[0]) check(int'(penalty) == q_pen[0], "R7 penalty", penalty, q_pen[0]);
        void'(q_cyc.pop_front());
        void'(q_dat.pop_front());
        void'(q_last.pop_front());
        void'(q_pen.pop_front());
      end else begin
        check(rd_last == 1'b0, "R6 last idle", rd_last, 0);
      end
    end
  end

  task automatic do_req(input logic [7:0] a, input logic [3:0] l, output bit taken);
    int e;
    int n;
    @(negedge clk);
    req = 1'b1; req_addr = a; req_len = l;
    e = cnt + 1;
    taken = !((acc_e <= e - 1) && (e - 1 < last_e));
    if (taken) begin
      n = (l == 0) ? 1 : int'(l);
      acc_e = e;
      last_e = e + 52 + 10 * (n - 1);
      for (int k = 0; k < n; k++) begin
        logic [7:0] wa;
        wa = {a[7:4], 4'(a[3:0] + 4'(k))};
        q_cyc.push_back(e + 52 + 10 * k);
        q_dat.push_back(mdl[wa]);
        q_last.push_back(k == n - 1);
        q_pen.push_back(52 + 10 * (n - 1));
      end
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    while (cnt <= last_e + 1) @(negedge clk);
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    mdl[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit tk;
    rst_n = 1'b0; req = 1'b0; req_addr = '0; req_len = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rd_valid == 1'b0, "R1 valid", rd_valid, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(penalty == 16'd0, "R1 penalty", penalty, 0);
    rst_n = 1'b1;
    live = 1'b1;
    // R9: fill the array through the write port
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      wr_en = 1'b1; wr_addr = 8'(i); wr_data = 32'hA500_0000 | (i * 32'h0001_0203);
      mdl[i] = wr_data;
      @(negedge clk);
    end
    wr_en = 1'b0;
    check(penalty == 16'd0, "R1 penalty held", penalty, 0);
    // R3 R7: single word, 52 cycles
    do_req(8'h05, 4'd1, tk); check(tk, "R2 accept", tk, 1); wait_idle();
    // R4 R7: four words, 82 cycles
    do_req(8'h10, 4'd4, tk); wait_idle();
    check(int'(penalty) == 82, "R7 penalty held", penalty, 82);
    // R5: column wraps within row
    do_req(8'h1E, 4'd4, tk); wait_idle();
    // R6: length 0 fetches one word
    do_req(8'h77, 4'd0, tk); wait_idle();
    check(int'(penalty) == 52, "R6 len0 penalty", penalty, 52);
    // R8: request while busy is dropped, request in final-word cycle is taken
    do_req(8'h20, 4'd3, tk);
    repeat (20) @(negedge clk);
    check(busy == 1'b1, "R8 busy before drop", busy, 1);
    do_req(8'h40, 4'd2, tk); check(!tk, "R8 dropped", tk, 0);
    while (cnt < last_e - 1) @(negedge clk);
    do_req(8'h3C, 4'd2, tk); check(tk, "R8 back-to-back", tk, 1);
    wait_idle();
    // R4 R5: longest burst, wrapping
    do_req(8'hF3, 4'd15, tk); wait_idle();
    // R9: rewrite a word and fetch it back
    do_wr(8'h85, 32'hDEAD_BEEF);
    do_wr(8'h86, 32'h0123_4567);
    do_req(8'h85, 4'd2, tk); wait_idle();
    repeat (5) @(negedge clk);
    check(q_cyc.size() == 0, "R3 all words returned", q_cyc.size(), 0);
    finish_run();
  end

endmodule